// File: doc/BRIEF.md
# Half-width PWM timer with prescale extension

A single down-counting timer channel built from a 16-bit main counter and an 8-bit prescale register. In the two counting modes, periodic and one-shot, the prescaler sits in front of the main counter as a clock divider. The counter then steps once every prescale+1 clocks, and a timeout pulse marks each expiry.

In PWM mode the prescaler takes a different role. The prescale register becomes the upper byte of a 24-bit period, and a prescale-match register becomes the upper byte of a 24-bit compare value. This widens the range of the channel instead of dividing its clock. The channel drives one PWM output. The output is high while the count is above the compare value and low for the rest of the period.

Load, match and both prescale bytes are written to shadow copies. The running period picks these up only at a reload or at enable, so a period already in progress keeps the values it started with. Software writes each value through its own strobe and data pair.

Top module: `pwm_ext_timer`

## Requirements
- R1: The mode code on `mode_in` is 2'b00 for periodic, 2'b01 for one-shot and 2'b10 for PWM; 2'b11 behaves as periodic. A mode write is ignored while the channel is enabled. `pwm_out` stays low in every mode except PWM.
- R2: In periodic and one-shot modes a prescale value P divides the clock by P+1. From enable, the first timeout is seen (L+1)*(P+1) clocks after the start, and in periodic mode later timeouts repeat at that interval, for load L.
- R3: In PWM mode the period uses the 24-bit value L = {prescale, load}. The counter runs L down to 0 and reloads, so each period is L+1 clocks and a timeout marks each reload.
- R4: In PWM mode, with M = {prescale_match, match}, `pwm_out` is high while the count is greater than M, giving L-M high clocks per period. When M >= L the output is constantly low. When M = 0 the output is constantly high.
- R5: Writing enable 0 stops the counter. While disabled, `pwm_out` is low and no timeout occurs. Writing enable 1 while disabled restarts the channel from the shadow load with a fresh prescale count, so the first PWM timeout follows L+1 clocks later.
- R6: Writes to load, match, prescale and prescale-match do not change the period in progress. They take effect at the next reload or enable.
- R7: In one-shot mode the channel gives a single timeout and then disables itself. It stays silent until it is enabled again.
- R8: `timeout` is a one-clock pulse. It is asserted in the clock that follows the counter's step at zero.
- R9: After reset the channel is disabled, every register is zero, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Strobe for the mode register |
| mode_in | input | 2 | Mode code (see R1) |
| load_wr | input | 1 | Strobe for the shadow load |
| load_in | input | 16 | Main counter reload value |
| match_wr | input | 1 | Strobe for the shadow match |
| match_in | input | 16 | Lower 16 bits of the PWM compare value |
| pre_wr | input | 1 | Strobe for the shadow prescale |
| pre_in | input | 8 | Prescale value: divider, or upper period byte |
| prem_wr | input | 1 | Strobe for the shadow prescale-match |
| prem_in | input | 8 | Upper byte of the PWM compare value |
| en_wr | input | 1 | Strobe for the enable bit |
| en_in | input | 1 | Enable value |
| timeout | output | 1 | One-clock expiry pulse |
| pwm_out | output | 1 | PWM output |

## Verification
The PWM function is tried with match values that fall inside the period, match values at zero, and match values equal to or above the load. These separate the normal duty count from the two saturated outputs. A period whose upper bytes are both non-zero shows whether the prescale bytes are used as the most significant bits rather than as a divider. The same prescale value in periodic mode must instead stretch the timeout interval by a factor of P+1, which tells the two roles of the prescaler apart.

A match write in the middle of a period must leave that period's high count unchanged and alter only the next one. Ignored mode writes are checked by watching the output and the timeout spacing. A long random run with interleaved writes, enables and mode changes is compared cycle by cycle against a reference model in the bench.

// File: rtl/pwm_ext_timer.sv
module pwm_ext_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [1:0]       mode_in,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_in,
  input  logic             match_wr,
  input  logic [CNT_W-1:0] match_in,
  input  logic             pre_wr,
  input  logic [PRE_W-1:0] pre_in,
  input  logic             prem_wr,
  input  logic [PRE_W-1:0] prem_in,
  input  logic             en_wr,
  input  logic             en_in,
  output logic             timeout,
  output logic             pwm_out
);
  localparam int W = CNT_W + PRE_W;
  localparam logic [1:0] MODE_ONE = 2'b01;
  localparam logic [1:0] MODE_PWM = 2'b10;

  logic [1:0]       mode_r;
  logic             en_r;
  logic [CNT_W-1:0] ld_sh, mt_sh;
  logic [PRE_W-1:0] pr_sh, pm_sh, act_pre, psc;
  logic [W-1:0]     act_match, cnt;

  wire is_pwm = (mode_r == MODE_PWM);
  wire is_one = (mode_r == MODE_ONE);
  wire [W-1:0] nxt_load  = is_pwm ? {pr_sh, ld_sh} : {{PRE_W{1'b0}}, ld_sh};
  wire [W-1:0] nxt_match = {pm_sh, mt_sh};
  wire start = en_wr && en_in && !en_r;
  wire tick  = is_pwm || (psc == '0);

  assign pwm_out = en_r && is_pwm && ((act_match == '0) || (cnt > act_match));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r    <= '0;
      en_r      <= 1'b0;
      ld_sh     <= '0;
      mt_sh     <= '0;
      pr_sh     <= '0;
      pm_sh     <= '0;
      act_pre   <= '0;
      psc       <= '0;
      act_match <= '0;
      cnt       <= '0;
      timeout   <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (load_wr)  ld_sh <= load_in;
      if (match_wr) mt_sh <= match_in;
      if (pre_wr)   pr_sh <= pre_in;
      if (prem_wr)  pm_sh <= prem_in;
      if (mode_wr && !en_r) mode_r <= mode_in;

      if (en_wr && !en_in) begin
        en_r <= 1'b0;
      end else if (start) begin
        en_r      <= 1'b1;
        cnt       <= nxt_load;
        act_match <= nxt_match;
        act_pre   <= pr_sh;
        psc       <= pr_sh;
      end else if (en_r) begin
        if (!is_pwm) psc <= (psc == '0) ? act_pre : psc - 1'b1;
        if (tick) begin
          if (cnt == '0) begin
            timeout <= 1'b1;
            if (is_one) begin
              en_r <= 1'b0;
            end else begin
              cnt       <= nxt_load;
              act_match <= nxt_match;
              act_pre   <= pr_sh;
              psc       <= pr_sh;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end

  // R2: no main-counter step while the divider is still counting
  a_r2_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r && !en_wr && !is_pwm && psc != '0) |=> $stable(cnt));

  // R3: the PWM count falls by one every clock
  a_r3_pwm_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r && !en_wr && is_pwm && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R5: a disabled channel holds its count and stays quiet
  a_r5_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_r && !en_wr) |=> ($stable(cnt) && !timeout));

  // R6: the active compare value only changes at a reload or an enable
  a_r6_match_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r && !en_wr && cnt != '0) |=> $stable(act_match));

  // R7: a one-shot expiry leaves the channel disabled
  a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && is_one) |-> !en_r);
endmodule

// File: tb/pwm_ext_timer_bench.sv
module pwm_ext_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 0, load_wr = 0, match_wr = 0, pre_wr = 0, prem_wr = 0, en_wr = 0, en_in = 0;
  logic [1:0]  mode_in = 0;
  logic [15:0] load_in = 0, match_in = 0;
  logic [7:0]  pre_in = 0, prem_in = 0;
  logic timeout, pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_ext_timer u_pwm_ext_timer (
    .clk(clk), .rst_n(rst_n),
    .mode_wr(mode_wr), .mode_in(mode_in),
    .load_wr(load_wr), .load_in(load_in),
    .match_wr(match_wr), .match_in(match_in),
    .pre_wr(pre_wr), .pre_in(pre_in),
    .prem_wr(prem_wr), .prem_in(prem_in),
    .en_wr(en_wr), .en_in(en_in),
    .timeout(timeout), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  logic [1:0]  m_mode;
  logic        m_en, m_to;
  logic [15:0] m_ld, m_mt;
  logic [7:0]  m_pr, m_pm, m_apre, m_psc;
  logic [23:0] m_match, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    logic pw, one, tk;
    logic [23:0] nl;
    if (!rst_n) begin
      m_mode <= 0; m_en <= 0; m_to <= 0; m_ld <= 0; m_mt <= 0; m_pr <= 0; m_pm <= 0;
      m_apre <= 0; m_psc <= 0; m_match <= 0; m_cnt <= 0;
    end else begin
      pw  = (m_mode == 2'b10);
      one = (m_mode == 2'b01);
      tk  = pw || (m_psc == 0);
      nl  = pw ? {m_pr, m_ld} : {8'h00, m_ld};
      m_to <= 0;
      if (load_wr)  m_ld <= load_in;
      if (match_wr) m_mt <= match_in;
      if (pre_wr)   m_pr <= pre_in;
      if (prem_wr)  m_pm <= prem_in;
      if (mode_wr && !m_en) m_mode <= mode_in;
      if (en_wr && !en_in) m_en <= 0;
      else if (en_wr && en_in && !m_en) begin
        m_en <= 1; m_cnt <= nl; m_match <= {m_pm, m_mt}; m_apre <= m_pr; m_psc <= m_pr;
      end else if (m_en) begin
        if (!pw) m_psc <= (m_psc == 0) ? m_apre : m_psc - 1;
        if (tk) begin
          if (m_cnt == 0) begin
            m_to <= 1;
            if (one) m_en <= 0;
            else begin
              m_cnt <= nl; m_match <= {m_pm, m_mt}; m_apre <= m_pr; m_psc <= m_pr;
            end
          end else m_cnt <= m_cnt - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_pwm;
      exp_pwm = m_en && (m_mode == 2'b10) && ((m_match == 0) || (m_cnt > m_match));
      check(pwm_out == exp_pwm, "R4", "model pwm_out", pwm_out, exp_pwm);
      check(timeout == m_to, "R8", "model timeout", timeout, m_to);
    end
  end

  task automatic poke(input int r, input int v);
    @(negedge clk);
    case (r)
      0: begin mode_wr = 1; mode_in = v[1:0]; end
      1: begin load_wr = 1; load_in = v[15:0]; end
      2: begin match_wr = 1; match_in = v[15:0]; end
      3: begin pre_wr = 1; pre_in = v[7:0]; end
      4: begin prem_wr = 1; prem_in = v[7:0]; end
      default: begin en_wr = 1; en_in = v[0]; end
    endcase
    @(negedge clk);
    mode_wr = 0; load_wr = 0; match_wr = 0; pre_wr = 0; prem_wr = 0; en_wr = 0;
  endtask

  task automatic en_run(output int n, output int hi);
    poke(5, 1);
    hi = pwm_out ? 1 : 0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!timeout && pwm_out) hi++;
    end while (!timeout);
  endtask

  task automatic wait_to();
    do @(negedge clk); while (!timeout);
  endtask

  task automatic measure_high(input int len, output int hi);
    wait_to();
    hi = 0;
    for (int i = 0; i <= len; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
  endtask

  task automatic measure_interval(output int n);
    wait_to();
    @(negedge clk);
    check(timeout == 0, "R8", "timeout pulse width", timeout, 0);
    n = 1;
    while (!timeout) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int n, hi, cnt_hi, cnt_to;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(pwm_out == 0, "R9", "pwm_out after reset", pwm_out, 0);
    check(timeout == 0, "R9", "timeout after reset", timeout, 0);

    poke(0, 2); poke(1, 9); poke(2, 3); poke(3, 0); poke(4, 0);
    en_run(n, hi);
    check(n == 10, "R3", "PWM period from enable", n, 10);
    check(hi == 6, "R4", "high clocks first period", hi, 6);
    measure_interval(n);
    check(n == 10, "R3", "PWM period steady", n, 10);
    measure_high(9, hi);
    check(hi == 6, "R4", "high clocks match 3", hi, 6);

    poke(2, 0);  measure_high(9, hi);
    check(hi == 10, "R4", "match 0 constant high", hi, 10);
    poke(2, 12); measure_high(9, hi);
    check(hi == 0, "R4", "match above load constant low", hi, 0);
    poke(2, 9);  measure_high(9, hi);
    check(hi == 0, "R4", "match equal load constant low", hi, 0);
    poke(2, 3);  measure_high(9, hi);
    check(hi == 6, "R4", "match 3 restored", hi, 6);

    wait_to();
    hi = 0;
    for (int i = 0; i <= 9; i++) begin
      if (i == 2) begin match_wr = 1; match_in = 7; end
      if (i == 3) match_wr = 0;
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check(hi == 6, "R6", "mid-period match write deferred", hi, 6);
    measure_high(9, hi);
    check(hi == 2, "R6", "new match applied at reload", hi, 2);

    poke(5, 0);
    cnt_hi = 0; cnt_to = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out) cnt_hi++;
      if (timeout) cnt_to++;
    end
    check(cnt_hi == 0, "R5", "pwm high while disabled", cnt_hi, 0);
    check(cnt_to == 0, "R5", "timeouts while disabled", cnt_to, 0);
    en_run(n, hi);
    check(n == 10, "R5", "restart from load after enable", n, 10);

    poke(5, 0); poke(3, 1); poke(1, 16); poke(4, 1); poke(2, 0);
    en_run(n, hi);
    check(n == 65553, "R3", "24-bit period with prescale upper byte", n, 65553);
    check(hi == 16, "R4", "24-bit compare with prescale-match byte", hi, 16);

    poke(5, 0); poke(4, 0); poke(0, 0); poke(3, 2); poke(1, 3);
    en_run(n, hi);
    check(n == 12, "R2", "periodic first timeout divide by 3", n, 12);
    check(hi == 0, "R1", "pwm_out low in periodic", hi, 0);
    measure_interval(n);
    check(n == 12, "R2", "periodic interval divide by 3", n, 12);
    poke(0, 2);
    cnt_hi = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_out) cnt_hi++;
    end
    check(cnt_hi == 0, "R1", "mode write while enabled ignored", cnt_hi, 0);
    measure_interval(n);
    check(n == 12, "R1", "interval after ignored mode write", n, 12);

    poke(5, 0); poke(3, 0); poke(1, 5);
    en_run(n, hi);
    check(n == 6, "R2", "periodic without prescale", n, 6);

    poke(5, 0); poke(0, 1); poke(3, 1); poke(1, 4);
    en_run(n, hi);
    check(n == 10, "R7", "one-shot expiry time", n, 10);
    cnt_to = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (timeout) cnt_to++;
    end
    check(cnt_to == 0, "R7", "one-shot stays stopped", cnt_to, 0);
    en_run(n, hi);
    check(n == 10, "R7", "one-shot re-armed by enable", n, 10);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      mode_wr  = ($urandom % 40) == 0; mode_in  = 2'($urandom % 4);
      load_wr  = ($urandom % 12) == 0; load_in  = 16'($urandom % 16);
      match_wr = ($urandom % 10) == 0; match_in = 16'($urandom % 18);
      pre_wr   = ($urandom % 20) == 0; pre_in   = 8'($urandom % 3);
      prem_wr  = ($urandom % 30) == 0; prem_in  = 8'($urandom % 2);
      en_wr    = ($urandom % 25) == 0; en_in    = ($urandom % 4) != 0;
    end
    @(negedge clk);
    mode_wr = 0; load_wr = 0; match_wr = 0; pre_wr = 0; prem_wr = 0; en_wr = 0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule